// File: doc/BRIEF.md
# Stop Mode Clock Controller

This block sits inside the clock and power unit of a microcontroller and manages its low-power stop state. On a stop request it shuts down the PLL and the internal reference oscillator. It closes the core, bus and debug clock gates and moves the voltage regulator into its reduced-power mode. It then waits for a wake-up pulse and brings the clocks back in a fixed order.

There are two kinds of stop. The controller enters pseudo stop when both the pseudo-stop enable and the external-oscillator enable are set. In pseudo stop the external oscillator keeps running, and the watchdog and periodic-interrupt clocks keep running when their own enables are set. Any other setting gives full stop, in which the external oscillator is also switched off. On wake-up, full stop forces the clock-select bits to fixed values: PLL as system clock, and the internal reference for the watchdog and for the periodic interrupt. Pseudo stop leaves those bits as they were. Before pseudo stop may begin, the external oscillator has to report that it is ready.

Top module: `stop_clk_ctrl`

## Requirements
- R1: In the cycle after a stop entry is taken, pll_en and irc_en are 0, core_gate, bus_gate and dbg_gate are 0, and reg_lowpwr is 1. All of them stay that way for as long as the controller is stopped.
- R2: `mode` reads 2'b00 in run, 2'b01 in full stop and 2'b10 in pseudo stop. A stop entry goes to pseudo stop exactly when cfg_pstop_en and cfg_osc_en are both 1 in the entry cycle, and to full stop otherwise.
- R3: xosc_en is 0 in full stop and 1 in pseudo stop. In run it follows cfg_osc_en with one cycle of delay.
- R4: On wake-up from full stop the select bits become pll_sel=1, wdog_osc_sel=0 and pit_osc_sel=0.
- R5: On wake-up from pseudo stop, pll_sel, wdog_osc_sel and pit_osc_sel keep the values they had before the stop.
- R6: wdog_run and pit_run follow cfg_wdog_en and cfg_pit_en in run and in pseudo stop, and are 0 in full stop.
- R7: A wake pulse in a stop state returns the controller to run (mode 2'b00) at the next edge. A wake pulse while in run has no effect.
- R8: A stop request while stopped is ignored. A change of cfg_pstop_en while stopped does not change the stop kind.
- R9: When pseudo stop is selected but osc_ready is 0, the controller stays in run with all clocks on and holds the request. It enters pseudo stop at the edge where osc_ready is first seen high.
- R10: On wake-up, pll_en and irc_en are 1 in the cycle after the wake pulse while the core, bus and debug gates are still 0. The gates are 1 one cycle later.
- R11: A cfg_wr pulse in run loads cfg_pll_sel, cfg_wdog_osc_sel and cfg_pit_osc_sel into the select outputs at the next edge. A cfg_wr pulse while stopped is ignored.
- R12: After reset, mode is run, pll_en, irc_en and all clock gates are 1, reg_lowpwr is 0, and all three select bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Stop request pulse |
| wake | input | 1 | Synchronous wake-up pulse |
| osc_ready | input | 1 | External oscillator has finished starting up |
| cfg_pstop_en | input | 1 | Pseudo-stop enable |
| cfg_osc_en | input | 1 | External oscillator enable |
| cfg_wdog_en | input | 1 | Watchdog enable |
| cfg_pit_en | input | 1 | Periodic-interrupt enable |
| cfg_wr | input | 1 | Write strobe for the select bits |
| cfg_pll_sel | input | 1 | Write data for PLL select |
| cfg_wdog_osc_sel | input | 1 | Write data for watchdog clock select |
| cfg_pit_osc_sel | input | 1 | Write data for periodic-interrupt clock select |
| mode | output | 2 | Current mode: 00 run, 01 full stop, 10 pseudo stop |
| pll_en | output | 1 | PLL enable |
| irc_en | output | 1 | Internal reference oscillator enable |
| xosc_en | output | 1 | External oscillator enable |
| reg_lowpwr | output | 1 | Regulator reduced-power mode |
| core_gate | output | 1 | Core clock gate open |
| bus_gate | output | 1 | Bus clock gate open |
| dbg_gate | output | 1 | Debug clock gate open |
| pll_sel | output | 1 | PLL selected as system clock |
| wdog_osc_sel | output | 1 | Watchdog clocked by the external oscillator |
| pit_osc_sel | output | 1 | Periodic interrupt clocked by the external oscillator |
| wdog_run | output | 1 | Watchdog clock running |
| pit_run | output | 1 | Periodic-interrupt clock running |

## Verification
The hardest case to reach is a held-back pseudo-stop request. It needs both stop-kind enables set while the oscillator is not yet ready, and then the ready signal has to rise several cycles after the request pulse has already gone. The bench sweeps every combination of the two stop-kind enables, the ready level, the run enables and three select-bit patterns. For each not-ready pseudo case it holds ready low for two cycles and then raises it. Inside each stop it also sends a second request, a select write and a flipped pseudo-stop enable, so that the ignore rules are exercised in both stop kinds.

// File: rtl/scc_pkg.sv
package scc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_FULL   = 2'b01,
    MODE_PSEUDO = 2'b10
  } scc_mode_e;

  localparam int SEL_W      = 3;  // {pit, wdog, pll}
  localparam int SEL_PLL    = 0;
  localparam int SEL_WDOG   = 1;
  localparam int SEL_PIT    = 2;
  localparam int GATE_W     = 3;  // {dbg, bus, core}
endpackage

// File: rtl/scc_mode_fsm.sv
module scc_mode_fsm
  import scc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      stop_req,
  input  logic      wake,
  input  logic      osc_ready,
  input  logic      pstop_en,
  input  logic      osc_en,
  output scc_mode_e state_q,
  output scc_mode_e state_d
);
  logic pend_q;
  logic req;
  logic want_pseudo;

  assign req         = stop_req | pend_q;
  assign want_pseudo = pstop_en & osc_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MODE_RUN: begin
        if (req) begin
          if (!want_pseudo)   state_d = MODE_FULL;
          else if (osc_ready) state_d = MODE_PSEUDO;
        end
      end
      MODE_FULL, MODE_PSEUDO: begin
        if (wake) state_d = MODE_RUN;
      end
      default: state_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MODE_RUN;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= (state_q == MODE_RUN) && (state_d == MODE_RUN) && req;
    end
  end
endmodule

// File: rtl/scc_gate_seq.sv
module scc_gate_seq
  import scc_pkg::*;
#(
  parameter int N_GATE = GATE_W
)(
  input  logic              clk,
  input  logic              rst,
  input  scc_mode_e         state_q,
  input  scc_mode_e         state_d,
  input  logic              osc_en,
  input  logic              wdog_en,
  input  logic              pit_en,
  output logic              pll_en,
  output logic              irc_en,
  output logic              xosc_en,
  output logic              reg_lowpwr,
  output logic [N_GATE-1:0] gates,
  output logic              wdog_run,
  output logic              pit_run
);
  logic run_next;
  logic run_both;

  assign run_next = (state_d == MODE_RUN);
  assign run_both = run_next && (state_q == MODE_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_en     <= 1'b1;
      irc_en     <= 1'b1;
      reg_lowpwr <= 1'b0;
      xosc_en    <= 1'b0;
      wdog_run   <= 1'b0;
      pit_run    <= 1'b0;
    end else begin
      pll_en     <= run_next;
      irc_en     <= run_next;
      reg_lowpwr <= !run_next;
      unique case (state_d)
        MODE_FULL:   xosc_en <= 1'b0;
        MODE_PSEUDO: xosc_en <= 1'b1;
        default:     xosc_en <= osc_en;
      endcase
      wdog_run <= (state_d != MODE_FULL) && wdog_en;
      pit_run  <= (state_d != MODE_FULL) && pit_en;
    end
  end

  for (genvar g = 0; g < N_GATE; g++) begin : g_gate
    always_ff @(posedge clk) begin
      if (rst) gates[g] <= 1'b1;
      else     gates[g] <= run_both;
    end
  end
endmodule

// File: rtl/scc_sel_regs.sv
module scc_sel_regs
  import scc_pkg::*;
#(
  parameter int               N_SEL     = SEL_W,
  parameter logic [N_SEL-1:0] RST_VAL   = '0,
  parameter logic [N_SEL-1:0] FORCE_VAL = 3'b001
)(
  input  logic             clk,
  input  logic             rst,
  input  scc_mode_e        state_q,
  input  scc_mode_e        state_d,
  input  logic             wr,
  input  logic [N_SEL-1:0] wdata,
  output logic [N_SEL-1:0] sel
);
  logic force_now;
  logic load_now;

  assign force_now = (state_q == MODE_FULL) && (state_d == MODE_RUN);
  assign load_now  = (state_q == MODE_RUN) && wr;

  for (genvar b = 0; b < N_SEL; b++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst)            sel[b] <= RST_VAL[b];
      else if (force_now) sel[b] <= FORCE_VAL[b];
      else if (load_now)  sel[b] <= wdata[b];
    end
  end
endmodule

// File: rtl/stop_clk_ctrl.sv
module stop_clk_ctrl
  import scc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req,
  input  logic       wake,
  input  logic       osc_ready,
  input  logic       cfg_pstop_en,
  input  logic       cfg_osc_en,
  input  logic       cfg_wdog_en,
  input  logic       cfg_pit_en,
  input  logic       cfg_wr,
  input  logic       cfg_pll_sel,
  input  logic       cfg_wdog_osc_sel,
  input  logic       cfg_pit_osc_sel,
  output logic [1:0] mode,
  output logic       pll_en,
  output logic       irc_en,
  output logic       xosc_en,
  output logic       reg_lowpwr,
  output logic       core_gate,
  output logic       bus_gate,
  output logic       dbg_gate,
  output logic       pll_sel,
  output logic       wdog_osc_sel,
  output logic       pit_osc_sel,
  output logic       wdog_run,
  output logic       pit_run
);
  scc_mode_e         st_q, st_d;
  logic [GATE_W-1:0] gates;
  logic [SEL_W-1:0]  sel_wdata, sel_q;

  scc_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wake(wake),
    .osc_ready(osc_ready), .pstop_en(cfg_pstop_en), .osc_en(cfg_osc_en),
    .state_q(st_q), .state_d(st_d)
  );

  scc_gate_seq #(.N_GATE(GATE_W)) u_seq (
    .clk(clk), .rst(rst), .state_q(st_q), .state_d(st_d),
    .osc_en(cfg_osc_en), .wdog_en(cfg_wdog_en), .pit_en(cfg_pit_en),
    .pll_en(pll_en), .irc_en(irc_en), .xosc_en(xosc_en),
    .reg_lowpwr(reg_lowpwr), .gates(gates),
    .wdog_run(wdog_run), .pit_run(pit_run)
  );

  assign sel_wdata[SEL_PLL]  = cfg_pll_sel;
  assign sel_wdata[SEL_WDOG] = cfg_wdog_osc_sel;
  assign sel_wdata[SEL_PIT]  = cfg_pit_osc_sel;

  scc_sel_regs #(.N_SEL(SEL_W), .RST_VAL(3'b000), .FORCE_VAL(3'b001)) u_sel (
    .clk(clk), .rst(rst), .state_q(st_q), .state_d(st_d),
    .wr(cfg_wr), .wdata(sel_wdata), .sel(sel_q)
  );

  assign mode         = st_q;
  assign core_gate    = gates[0];
  assign bus_gate     = gates[1];
  assign dbg_gate     = gates[2];
  assign pll_sel      = sel_q[SEL_PLL];
  assign wdog_osc_sel = sel_q[SEL_WDOG];
  assign pit_osc_sel  = sel_q[SEL_PIT];
endmodule

// File: rtl/scc_checker.sv
module scc_checker (
  input logic       clk,
  input logic       rst,
  input logic       stop_req,
  input logic       wake,
  input logic       osc_ready,
  input logic       cfg_wr,
  input logic [1:0] mode,
  input logic       pll_en,
  input logic       irc_en,
  input logic       xosc_en,
  input logic       reg_lowpwr,
  input logic       core_gate,
  input logic       bus_gate,
  input logic       dbg_gate,
  input logic       pll_sel,
  input logic       wdog_osc_sel,
  input logic       pit_osc_sel,
  input logic       wdog_run,
  input logic       pit_run
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_STOP_CLOCKS_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b00) |-> (!pll_en && !irc_en && !core_gate && !bus_gate && !dbg_gate && reg_lowpwr)); // R1
  AST_FULL_XOSC_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |-> (!xosc_en && !wdog_run && !pit_run)); // R3
  AST_PSEUDO_XOSC_ON: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> xosc_en); // R3
  AST_FULL_WAKE_SEL: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(mode) == 2'b01 && mode == 2'b00) |-> (pll_sel && !wdog_osc_sel && !pit_osc_sel)); // R4
  AST_PSEUDO_WAKE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(mode) == 2'b10 && mode == 2'b00) |-> ($stable(pll_sel) && $stable(wdog_osc_sel) && $stable(pit_osc_sel))); // R5
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b00 && !wake) |=> $stable(mode)); // R8
  AST_PSEUDO_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(mode) == 2'b00 && mode == 2'b10) |-> $past(osc_ready)); // R9
  AST_WAKE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(mode) != 2'b00 && mode == 2'b00) |-> (pll_en && irc_en && !core_gate)); // R10
  AST_WAKE_GATES_OPEN: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(mode) != 2'b00 && mode == 2'b00 && !stop_req) |=> (core_gate && bus_gate && dbg_gate)); // R10
  AST_STOP_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b00 && !wake && cfg_wr) |=> ($stable(pll_sel) && $stable(wdog_osc_sel) && $stable(pit_osc_sel))); // R11
endmodule

bind stop_clk_ctrl scc_checker u_scc_chk (
  .clk(clk), .rst(rst), .stop_req(stop_req), .wake(wake), .osc_ready(osc_ready),
  .cfg_wr(cfg_wr), .mode(mode), .pll_en(pll_en), .irc_en(irc_en),
  .xosc_en(xosc_en), .reg_lowpwr(reg_lowpwr), .core_gate(core_gate),
  .bus_gate(bus_gate), .dbg_gate(dbg_gate), .pll_sel(pll_sel),
  .wdog_osc_sel(wdog_osc_sel), .pit_osc_sel(pit_osc_sel),
  .wdog_run(wdog_run), .pit_run(pit_run)
);

// File: tb/tb_stop_clk_ctrl.sv
`timescale 1ns/1ps
module tb_stop_clk_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 0, wake = 0, osc_ready = 0;
  logic cfg_pstop_en = 0, cfg_osc_en = 0, cfg_wdog_en = 0, cfg_pit_en = 0;
  logic cfg_wr = 0, cfg_pll_sel = 0, cfg_wdog_osc_sel = 0, cfg_pit_osc_sel = 0;
  logic [1:0] mode;
  logic pll_en, irc_en, xosc_en, reg_lowpwr, core_gate, bus_gate, dbg_gate;
  logic pll_sel, wdog_osc_sel, pit_osc_sel, wdog_run, pit_run;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  stop_clk_ctrl dut (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wake(wake), .osc_ready(osc_ready),
    .cfg_pstop_en(cfg_pstop_en), .cfg_osc_en(cfg_osc_en), .cfg_wdog_en(cfg_wdog_en),
    .cfg_pit_en(cfg_pit_en), .cfg_wr(cfg_wr), .cfg_pll_sel(cfg_pll_sel),
    .cfg_wdog_osc_sel(cfg_wdog_osc_sel), .cfg_pit_osc_sel(cfg_pit_osc_sel),
    .mode(mode), .pll_en(pll_en), .irc_en(irc_en), .xosc_en(xosc_en),
    .reg_lowpwr(reg_lowpwr), .core_gate(core_gate), .bus_gate(bus_gate),
    .dbg_gate(dbg_gate), .pll_sel(pll_sel), .wdog_osc_sel(wdog_osc_sel),
    .pit_osc_sel(pit_osc_sel), .wdog_run(wdog_run), .pit_run(pit_run)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] sels();
    return {pit_osc_sel, wdog_osc_sel, pll_sel};
  endfunction

  task automatic write_sel(input logic [2:0] v);
    cfg_wr = 1'b1;
    {cfg_pit_osc_sel, cfg_wdog_osc_sel, cfg_pll_sel} = v;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 1'b0;
    step();
    chk("R12 mode", mode, 2'b00);
    chk("R12 enables/gates/lowpwr", {pll_en, irc_en, core_gate, bus_gate, dbg_gate, reg_lowpwr}, 6'b111110);
    chk("R12 selects", sels(), 3'b000);

    for (int c = 0; c < 64; c++) begin
      logic pst, osc, rdy, wden, piten, ps;
      logic [2:0] selv;
      pst   = c[0];
      osc   = c[1];
      rdy   = c[2];
      wden  = c[3];
      piten = c[4];
      selv  = c[5:3] ^ {c[0], c[1], c[2]};
      ps    = pst & osc;

      cfg_pstop_en = pst; cfg_osc_en = osc; osc_ready = rdy;
      cfg_wdog_en = wden; cfg_pit_en = piten;
      write_sel(selv);
      step();
      cfg_wr = 1'b0;
      step();
      chk("R11 select write in run", sels(), selv);
      chk("R3 xosc follows enable in run", xosc_en, osc);
      chk("R6 run enables in run", {wdog_run, pit_run}, {wden, piten});

      wake = 1'b1;
      step();
      wake = 1'b0;
      chk("R7 wake in run ignored", mode, 2'b00);

      stop_req = 1'b1;
      step();
      stop_req = 1'b0;
      if (ps && !rdy) begin
        chk("R9 held while not ready", mode, 2'b00);
        chk("R9 clocks still on", {pll_en, core_gate, reg_lowpwr}, 3'b110);
        step();
        chk("R9 still held", mode, 2'b00);
        osc_ready = 1'b1;
        step();
      end
      chk("R2 stop kind", mode, ps ? 2'b10 : 2'b01);
      chk("R1 stop outputs", {pll_en, irc_en, core_gate, bus_gate, dbg_gate, reg_lowpwr}, 6'b000001);
      chk("R3 xosc in stop", xosc_en, ps);
      chk("R6 run enables in stop", {wdog_run, pit_run}, ps ? {wden, piten} : 2'b00);

      stop_req = 1'b1;
      cfg_pstop_en = ~pst;
      write_sel(~selv);
      step();
      stop_req = 1'b0;
      cfg_wr = 1'b0;
      step();
      chk("R8 stop kind unchanged", mode, ps ? 2'b10 : 2'b01);
      chk("R11 write ignored in stop", sels(), selv);
      cfg_pstop_en = pst;

      wake = 1'b1;
      step();
      wake = 1'b0;
      chk("R7 wake returns to run", mode, 2'b00);
      chk("R10 oscillators first", {pll_en, irc_en, core_gate, bus_gate, dbg_gate}, 5'b11000);
      if (ps) chk("R5 pseudo wake keeps selects", sels(), selv);
      else    chk("R4 full wake forces selects", sels(), 3'b001);
      step();
      chk("R10 gates open", {core_gate, bus_gate, dbg_gate, reg_lowpwr}, 4'b1110);
      osc_ready = 1'b0;
      step();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule